// File: doc/BRIEF.md
# Collision Presence Signaling Controller

This block decides when a 10 Mb/s twisted-pair attachment unit is in collision and produces the collision-presence indication toward the station. It watches two synchronous activity flags: one for data arriving from the station for transmission, and one for activity on the twisted-pair receive side. It also watches a link-failure flag and a one-cycle bit-time tick that marks each 100 ns bit time. All delays are counted in those ticks, so the block runs from any clock faster than the bit rate.

A collision is recognised only while both sides are active and the link is healthy. Once that overlap has lasted long enough, the block raises a collision flag and a registered enable for the 10 MHz collision signal generator. When the overlap ends, the block keeps signalling for a hold-off period. The length of that period depends on which side went quiet first. A separate timer moves the loopback data path from transmit data to receive data after the overlap has lasted a set number of bit times.

Top module: `col_presence_ctrl`

## Requirements
- R1: After reset, col_active, col_sig_en and lb_rx are all 0.
- R2: The collision condition is tx_act=1, rx_act=1 and link_fail=0 together. No collision is reported without it. An overlap that ends before REPORT_TICKS ticks have been counted raises nothing.
- R3: While the condition holds, col_active rises on the clock edge after the edge that sees the condition with REPORT_TICKS ticks already counted. The default of 4 keeps the report well inside 9 bit times.
- R4: col_sig_en is a register output that equals col_active in every cycle. It enables the 10 MHz collision signal.
- R5: If the condition ends with rx_act=0 and tx_act=1, signalling stays on for RXIDLE_HOLD further ticks (default 7). It clears on the edge after the edge that sees the count at zero.
- R6: If the condition ends with tx_act=0 (receive still active, or both idle), the hold uses TXIDLE_HOLD ticks instead (default 4, no more than 9).
- R7: If the condition returns during a hold, signalling stays on without a gap. The next hold reloads its full count.
- R8: link_fail=1 clears col_active, col_sig_en and lb_rx on the next clock edge, and blocks both timers while it stays high.
- R9: lb_rx (1 = loop back receive data, 0 = loop back transmit data) rises after SWITCH_TICKS ticks of the condition (default 13). It returns to 0 on the edge after the condition ends.
- R10: Only cycles with bt_tick=1 advance the report, switch and hold counters. Widening the spacing between ticks stretches every delay by the same factor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_act | input | 1 | Transmit-data pair activity from the station |
| rx_act | input | 1 | Twisted-pair receive activity |
| link_fail | input | 1 | Link-integrity failure flag |
| bt_tick | input | 1 | One-cycle pulse per 100 ns bit time |
| col_active | output | 1 | Collision state, including hold-off |
| col_sig_en | output | 1 | Registered enable for the 10 MHz collision signal |
| lb_rx | output | 1 | Loopback source select, 1 = receive data |

## Verification
The bench builds the block with its default counts: report 4, switch 13, receive-idle hold 7 and transmit-idle hold 4. With these values the hold that follows a receive-idle exit and the hold that follows a transmit-idle exit give visibly different lengths. The loopback switch also lands well after the collision report. The bench drives the bit-time tick every clock, every second, third and fourth clock. This shows that each delay scales with the tick rather than with the clock. It also reaches the edge cases where a hold re-enters the active state, and where link failure strikes both during the report delay and during an established collision.

// File: rtl/col_presence_ctrl.sv
module col_presence_ctrl #(
  parameter int REPORT_TICKS = 4,
  parameter int SWITCH_TICKS = 13,
  parameter int RXIDLE_HOLD  = 7,
  parameter int TXIDLE_HOLD  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_act,
  input  logic rx_act,
  input  logic link_fail,
  input  logic bt_tick,
  output logic col_active,
  output logic col_sig_en,
  output logic lb_rx
);

  localparam int RW   = $clog2(REPORT_TICKS + 2);
  localparam int SW   = $clog2(SWITCH_TICKS + 2);
  localparam int HMAX = (RXIDLE_HOLD > TXIDLE_HOLD) ? RXIDLE_HOLD : TXIDLE_HOLD;
  localparam int HW   = $clog2(HMAX + 2);

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_HOLD} st_t;

  st_t st, st_nx;
  logic [RW-1:0] rep_cnt;
  logic [SW-1:0] sw_cnt;
  logic [HW-1:0] hold_cnt;

  wire cond     = tx_act & rx_act & ~link_fail;
  wire rep_done = (rep_cnt == RW'(REPORT_TICKS));
  wire sw_done  = (sw_cnt == SW'(SWITCH_TICKS));

  always_comb begin
    st_nx = st;
    if (link_fail) st_nx = S_IDLE;
    else begin
      case (st)
        S_IDLE:  if (cond && rep_done) st_nx = S_ACT;
        S_ACT:   if (!cond) st_nx = S_HOLD;
        S_HOLD:  if (cond) st_nx = S_ACT;
                 else if (hold_cnt == '0) st_nx = S_IDLE;
        default: st_nx = S_IDLE;
      endcase
    end
  end

  assign col_active = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      col_sig_en <= 1'b0;
      rep_cnt    <= '0;
      hold_cnt   <= '0;
    end else begin
      st         <= st_nx;
      col_sig_en <= (st_nx != S_IDLE);
      if (st != S_IDLE || !cond) rep_cnt <= '0;
      else if (bt_tick && !rep_done) rep_cnt <= rep_cnt + 1'b1;
      if (st == S_ACT && st_nx == S_HOLD)
        hold_cnt <= tx_act ? HW'(RXIDLE_HOLD) : HW'(TXIDLE_HOLD);
      else if (st == S_HOLD && bt_tick && hold_cnt != '0)
        hold_cnt <= hold_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_cnt <= '0;
      lb_rx  <= 1'b0;
    end else if (!cond) begin
      sw_cnt <= '0;
      lb_rx  <= 1'b0;
    end else if (!lb_rx) begin
      if (sw_done) lb_rx <= 1'b1;
      else if (bt_tick) sw_cnt <= sw_cnt + 1'b1;
    end
  end

  // R8
  a_r8_fail_clears: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail |=> (!col_active && !col_sig_en && !lb_rx));

  // R2, R3
  a_r3_rise_needs_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_active) |-> $past(tx_act && rx_act && !link_fail));

  // R4
  a_r4_enable_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    col_sig_en == col_active);

  // R9
  a_r9_lb_needs_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    lb_rx |-> $past(tx_act && rx_act && !link_fail));

  // R9
  a_r9_lb_after_collision: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lb_rx) |-> col_active);

endmodule

// File: tb/tb_col_presence_ctrl.sv
`timescale 1ns/1ps
module tb_col_presence_ctrl;
  localparam int REP = 4, SWT = 13, RXH = 7, TXH = 4;

  logic clk = 0, rst_n = 0;
  logic tx_act = 0, rx_act = 0, link_fail = 0, bt_tick = 0;
  logic col_active, col_sig_en, lb_rx;

  col_presence_ctrl #(.REPORT_TICKS(REP), .SWITCH_TICKS(SWT),
                      .RXIDLE_HOLD(RXH), .TXIDLE_HOLD(TXH)) dut (
    .clk(clk), .rst_n(rst_n), .tx_act(tx_act), .rx_act(rx_act),
    .link_fail(link_fail), .bt_tick(bt_tick),
    .col_active(col_active), .col_sig_en(col_sig_en), .lb_rx(lb_rx));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  string tag = "R1";
  int tick_div = 1, phase = 0;
  bit done = 0;

  // behavioural reference
  int m_col, m_pend, m_hold, m_lb, m_sw;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_col = 0; m_pend = 0; m_hold = -1; m_lb = 0; m_sw = 0;
    end else begin
      automatic bit c = tx_act && rx_act && !link_fail;
      if (!c) begin m_sw = 0; m_lb = 0; end
      else if (m_lb == 0) begin
        if (m_sw == SWT) m_lb = 1; else if (bt_tick) m_sw++;
      end
      if (link_fail) begin m_col = 0; m_pend = 0; m_hold = -1; end
      else if (c) begin
        m_pend = m_col ? 0 : m_pend;
        if (m_col) m_hold = -1;
        else if (m_pend == REP) begin m_col = 1; m_pend = 0; end
        else if (bt_tick) m_pend++;
      end else begin
        m_pend = 0;
        if (m_col) begin
          if (m_hold < 0) m_hold = tx_act ? RXH : TXH;
          else if (m_hold == 0) begin m_col = 0; m_hold = -1; end
          else if (bt_tick) m_hold--;
        end
      end
    end
  end

  task automatic chk(string t, string what, logic got, int exp);
    checks++;
    if (got !== exp[0]) begin
      errors++;
      $display("FAIL %s %s got %0b expected %0d at %0t", t, what, got, exp, $time);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(tag, "col_active", col_active, m_col);
      chk("R4", "col_sig_en", col_sig_en, m_col);
      chk(tag, "lb_rx", lb_rx, m_lb);
      phase = (phase + 1) % tick_div;
      bt_tick = (phase == 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "col_active", col_active, 0);
    chk("R1", "col_sig_en", col_sig_en, 0);
    chk("R1", "lb_rx", lb_rx, 0);
    rst_n = 1;
    step(4);

    tag = "R3"; tx_act = 1; rx_act = 1; step(30);
    tag = "R5"; rx_act = 0; step(15);
    tx_act = 0; step(5);

    tag = "R6"; tick_div = 2; tx_act = 1; rx_act = 1; step(40);
    tx_act = 0; step(20);
    rx_act = 0; step(5);
    tx_act = 1; rx_act = 1; step(20);
    tx_act = 0; rx_act = 0; step(15);

    tag = "R2"; tick_div = 1; tx_act = 1; rx_act = 1; step(3);
    rx_act = 0; step(8);
    tx_act = 0; rx_act = 1; step(8);
    rx_act = 0; step(3);

    tag = "R7"; tx_act = 1; rx_act = 1; step(20);
    rx_act = 0; step(3);
    rx_act = 1; step(5);
    rx_act = 0; step(20);
    tx_act = 0; step(3);

    tag = "R8"; tx_act = 1; rx_act = 1; step(30);
    link_fail = 1; step(6);
    link_fail = 0; step(3);
    link_fail = 1; step(2);
    link_fail = 0; step(25);
    tx_act = 0; rx_act = 0; step(12);

    tag = "R9"; tick_div = 3; tx_act = 1; rx_act = 1; step(60);
    rx_act = 0; step(30);
    tx_act = 0; step(4);

    tag = "R10"; tick_div = 4; tx_act = 1; rx_act = 1; step(80);
    tx_act = 0; step(40);
    rx_act = 0; step(5);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule